// File: doc/BRIEF.md
# MDIO Management Master with Host Registers

This block lets a host read and write PHY management registers over the two-wire MDC/MDIO line. The host sees two 16-bit registers on a simple register bus. The first is a command word. It holds the PHY address, the register number, the direction, a clock-divide code and a busy flag. The second is a data word.

To start a transaction, the host writes the command word with the busy flag set. It then polls that flag until the flag reads back as zero. For a write, the value to send must already be in the data word. For a read, the returned value appears in the data word once the flag has dropped.

On the line side, the block makes MDC from the system clock and drives MDIO through an output enable, so that the PHY can drive the line during a read. Each frame is 64 bits long:

- 32 preamble ones
- start pattern `01`
- opcode (`10` for a read, `01` for a write)
- PHY address, then register number
- a two-bit turnaround
- 16 data bits

Every field goes out most significant bit first. The master changes the bits it drives on the falling edge of MDC, and it samples read data on the rising edge.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, the command and data words both read 0, MDC is 0 and the MDIO output enable is 0.
- R2: The command word (host address 0) holds these fields. Bit 0 is busy. Bit 1 is the direction, with 1 for write and 0 for read. Bits 4:2 are the divide code. Bits 10:6 are the register number. Bits 15:11 are the PHY address. Bit 5 always reads 0. The data word is at host address 1.
- R3: A command write with bit 0 set, made while idle, starts a frame. The busy bit then reads 1 until the last MDC falling edge of the frame and reads 0 afterwards. A frame has exactly 64 MDC rising edges.
- R4: At successive MDC rising edges, a write frame presents on MDIO, with the output enable at 1 throughout: 32 ones, `01`, `01`, the PHY address, the register number, `10`, and then the data word, each field MSB first. The driven bit changes only while MDC is low.
- R5: A read frame sends `10` as its opcode and holds the output enable at 0 from bit 46, the turnaround, through bit 63. It samples MDIO on the 16 final rising edges, MSB first. Once busy has cleared, the data word holds the sampled value.
- R6: Divide codes 0, 1, 2, 3, 4 and 5 give an MDC period of 42, 62, 16, 26, 102 and 124 system clocks. Codes 6 and 7 give 124.
- R7: MDC stays at 0 whenever no frame is in progress.
- R8: A command write made while busy is 1 changes no field of the command word and does not alter the frame in progress.
- R9: A command write with bit 0 clear, made while idle, updates the fields but produces no MDC edge and leaves busy at 0.
- R10: A data-word write made while busy is 1 is ignored. Neither the frame being sent nor the data word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the register bus |
| host_addr | input | 1 | Register select: 0 for the command word, 1 for the data word |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the selected register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; 0 releases the line |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
A wrong bit counter or shift register appears on the line at once, as a misplaced or missing field at a specific MDC rising edge. Such an error is therefore caught within the frame in which it happens, at the exact bit index. A busy flag that is out of step with the frame engine shows up at the host as a flag that clears too early or never clears. It is caught within one poll after the 64th MDC edge. A divider that has lost its place changes the spacing between MDC edges, so it is visible from the second rising edge of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W     = 16;
    localparam int PHY_W      = 5;
    localparam int REGN_W     = 5;
    localparam int CODE_W     = 3;
    localparam int DIV_CNT_W  = 7;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + PHY_W + REGN_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_BITS + 4 + PHY_W + REGN_W);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PRE_BITS + 6 + PHY_W + REGN_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_DATA = 1'b1
    } host_sel_e;

    typedef struct packed {
        logic [PHY_W-1:0]  phy;
        logic [REGN_W-1:0] regn;
        logic [CODE_W-1:0] code;
        logic              is_wr;
    } mgmt_cmd_t;

    function automatic mgmt_cmd_t unpack_cmd(input logic [DATA_W-1:0] w);
        mgmt_cmd_t c;
        c.phy   = w[15:11];
        c.regn  = w[10:6];
        c.code  = w[4:2];
        c.is_wr = w[1];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cmd(input mgmt_cmd_t c, input logic busy);
        return {c.phy, c.regn, 1'b0, c.code, c.is_wr, busy};
    endfunction

    // half of the MDC period in system clocks
    function automatic logic [DIV_CNT_W-1:0] half_period(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return DIV_CNT_W'(21);
            3'd1:    return DIV_CNT_W'(31);
            3'd2:    return DIV_CNT_W'(8);
            3'd3:    return DIV_CNT_W'(13);
            3'd4:    return DIV_CNT_W'(51);
            default: return DIV_CNT_W'(62);
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_cmd_t c,
                                                          input logic [DATA_W-1:0] d);
        logic [1:0] op;
        op = c.is_wr ? 2'b01 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, 2'b10,
                (c.is_wr ? d : {DATA_W{1'b0}})};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int CNT_W = mdio_pkg::DIV_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);

    logic [CNT_W-1:0] cnt;
    logic             mdc_q;
    logic             tick;

    assign tick = run && (cnt == half - CNT_W'(1));
    assign rise = tick && !mdc_q;
    assign fall = tick && mdc_q;
    assign mdc  = mdc_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (tick) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // R6: the phase counter never passes the selected half period
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < half));

    // R7: the clock cannot start high from idle
    a_r7_no_high_from_idle: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdc,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_in,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DIV_CNT_W-1:0] half,
    output logic              mdio_out,
    output logic              mdio_oe
);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    mgmt_cmd_t             cmd_q;
    logic [DATA_W-1:0]     rsh;

    assign half     = half_period(cmd_q.code);
    assign done     = active && fall && (idx == LAST_IDX);
    assign rdata    = rsh;
    assign mdio_out = active && shreg[FRAME_BITS-1];
    assign mdio_oe  = active && (cmd_q.is_wr || (idx < TA_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            cmd_q  <= '0;
            rsh    <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                shreg  <= build_frame(cmd, wdata);
                idx    <= '0;
                cmd_q  <= cmd;
                rsh    <= '0;
            end
        end else begin
            if (rise && !cmd_q.is_wr && (idx >= DATA_IDX))
                rsh <= {rsh[DATA_W-2:0], mdio_in};
            if (fall) begin
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                end else begin
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                    idx   <= idx + IDX_W'(1);
                end
            end
        end
    end

    // R7: no management clock outside a frame
    a_r7_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mdc);

    // R4: the driven bit holds while MDC stays high
    a_r4_hold_while_high: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_out));

    // R5: a released line is only ever sampled in a read frame
    a_r5_release_only_read: assert property (@(posedge clk) disable iff (rst)
        (active && !mdio_oe) |-> !cmd_q.is_wr);

endmodule

// File: rtl/mdio_hostregs.sv
module mdio_hostregs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_data,
    output logic              start,
    output mgmt_cmd_t         start_cmd,
    output logic [DATA_W-1:0] data_q,
    output logic              busy
);

    mgmt_cmd_t cmd_q;
    logic      cmd_wr;
    logic      data_wr;

    assign cmd_wr    = host_wr && (host_sel_e'(host_addr) == SEL_CMD);
    assign data_wr   = host_wr && (host_sel_e'(host_addr) == SEL_DATA);
    assign start     = cmd_wr && !busy && host_wdata[0];
    assign start_cmd = unpack_cmd(host_wdata);

    assign host_rdata = (host_sel_e'(host_addr) == SEL_CMD) ? pack_cmd(cmd_q, busy) : data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            busy   <= 1'b0;
            data_q <= '0;
        end else begin
            if (cmd_wr && !busy) begin
                cmd_q <= unpack_cmd(host_wdata);
                busy  <= host_wdata[0];
            end
            if (data_wr && !busy)
                data_q <= host_wdata;
            if (done) begin
                busy <= 1'b0;
                if (!cmd_q.is_wr)
                    data_q <= rx_data;
            end
        end
    end

    // R8: command fields are frozen while a frame runs
    a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_wr) |=> $stable(cmd_q));

    // R10: data word is frozen against host writes while busy
    a_r10_data_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && data_wr && !done) |=> $stable(data_q));

    // R3: completion drops the busy flag
    a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);

    logic              start;
    mgmt_cmd_t         start_cmd;
    logic [DATA_W-1:0] data_q;
    logic              busy;
    logic              active;
    logic              done;
    logic [DATA_W-1:0] rx_data;
    logic [DIV_CNT_W-1:0] half;
    logic              rise;
    logic              fall;

    mdio_hostregs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .done       (done),
        .rx_data    (rx_data),
        .start      (start),
        .start_cmd  (start_cmd),
        .data_q     (data_q),
        .busy       (busy)
    );

    mdio_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .cmd      (start_cmd),
        .wdata    (data_q),
        .mdc      (mdc),
        .rise     (rise),
        .fall     (fall),
        .mdio_in  (mdio_in),
        .active   (active),
        .done     (done),
        .rdata    (rx_data),
        .half     (half),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    mdio_clkgen #(.CNT_W(DIV_CNT_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (active),
        .half (half),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    // R3: host-visible busy follows the frame engine exactly
    a_r3_busy_tracks_frame: assert property (@(posedge clk) disable iff (rst)
        busy == active);

endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_addr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    always #5 clk = ~clk;

    mdio_mgmt_master i_mdio_mgmt_master (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    int n_cmp = 0;
    int n_mis = 0;
    int cyc = 0;
    int rc = 0;
    logic [15:0] phy_val = 16'h0;
    logic cap_v  [64];
    logic cap_oe [64];
    int   rise_t [64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            n_mis = n_mis + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end

    // PHY model: record line at each MDC rising edge, present read data
    assign mdio_in = (rc >= 48 && rc < 64) ? phy_val[63 - rc] : 1'b1;

    always @(posedge mdc) begin
        if (rc < 64) begin
            cap_v[rc]  = mdio_out;
            cap_oe[rc] = mdio_oe;
            rise_t[rc] = cyc;
        end
        rc = rc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] cword(input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [2:0] code, input logic wr, input logic bsy);
        return {phy, rg, 1'b0, code, wr, bsy};
    endfunction

    function automatic logic [63:0] exp_frame(input logic [4:0] phy, input logic [4:0] rg,
                                              input logic wr, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, d};
    endfunction

    task automatic host_write(input logic a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic wait_idle(output int polls);
        logic [15:0] v;
        polls = 0;
        v = 16'h1;
        while (v[0] && polls < 20000) begin
            host_read(1'b0, v);
            polls++;
        end
    endtask

    task automatic cmp_line(input string tag, input logic [63:0] exp, input int nbits, input bit oe_exp);
        int bad = -1;
        for (int i = 0; i < nbits; i++)
            if (cap_oe[i] !== oe_exp || cap_v[i] !== exp[63 - i]) begin
                if (bad < 0) bad = i;
            end
        chk(bad < 0, tag, 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        host_read(1'b0, v); chk(v == 16'h0, "R1 cmd after reset", v, 0);
        host_read(1'b1, v); chk(v == 16'h0, "R1 data after reset", v, 0);
        chk({mdc, mdio_oe} == 2'b00, "R1/R7 line idle after reset", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_fields_no_start;
        logic [15:0] v;
        rc = 0;
        host_write(1'b0, 16'hFFFE);
        host_read(1'b0, v);
        chk(v == 16'hFFDE, "R2 field readback bit5 zero", v, 16'hFFDE);
        repeat (300) @(negedge clk);
        chk(rc == 0, "R9 no MDC edge after busy-0 write", rc, 0);
        host_read(1'b0, v);
        chk(v[0] == 1'b0, "R9 busy stays 0", v[0], 0);
    endtask

    task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [15:0] v;
        int p;
        host_write(1'b1, d);
        rc = 0;
        host_write(1'b0, cword(phy, rg, 3'd2, 1'b1, 1'b1));
        host_read(1'b0, v);
        chk(v == cword(phy, rg, 3'd2, 1'b1, 1'b1), "R2/R3 busy set with fields", v,
            cword(phy, rg, 3'd2, 1'b1, 1'b1));
        while (rc < 64) @(negedge clk);
        host_read(1'b0, v);
        chk(v[0] == 1'b1, "R3 busy still 1 at last rising edge", v[0], 1);
        wait_idle(p);
        chk(rc == 64, "R3 exactly 64 MDC rises", rc, 64);
        cmp_line("R4 write frame bits", exp_frame(phy, rg, 1'b1, d), 64, 1'b1);
        chk(mdc == 1'b0, "R7 MDC low after frame", mdc, 0);
    endtask

    task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] val);
        logic [15:0] v;
        int p;
        int bad;
        phy_val = val;
        rc = 0;
        host_write(1'b0, cword(phy, rg, 3'd2, 1'b0, 1'b1));
        wait_idle(p);
        cmp_line("R5 read frame header", exp_frame(phy, rg, 1'b0, 16'h0), 46, 1'b1);
        bad = 0;
        for (int i = 46; i < 64; i++) if (cap_oe[i] !== 1'b0) bad++;
        chk(bad == 0, "R5 line released turnaround and data", bad, 0);
        host_read(1'b1, v);
        chk(v == val, "R5 read data in data word", v, val);
    endtask

    task automatic t_ignore_cmd;
        logic [15:0] v;
        int p;
        host_write(1'b1, 16'h5A3C);
        rc = 0;
        host_write(1'b0, cword(5'h03, 5'h04, 3'd2, 1'b1, 1'b1));
        repeat (100) @(negedge clk);
        host_write(1'b0, cword(5'h1C, 5'h1B, 3'd0, 1'b0, 1'b1));
        host_write(1'b0, cword(5'h1C, 5'h1B, 3'd5, 1'b0, 1'b0));
        host_read(1'b0, v);
        chk(v == cword(5'h03, 5'h04, 3'd2, 1'b1, 1'b1), "R8 fields unchanged while busy", v,
            cword(5'h03, 5'h04, 3'd2, 1'b1, 1'b1));
        wait_idle(p);
        cmp_line("R8 frame undisturbed", exp_frame(5'h03, 5'h04, 1'b1, 16'h5A3C), 64, 1'b1);
    endtask

    task automatic t_ignore_data;
        logic [15:0] v;
        int p;
        host_write(1'b1, 16'hC001);
        rc = 0;
        host_write(1'b0, cword(5'h0F, 5'h10, 3'd2, 1'b1, 1'b1));
        repeat (50) @(negedge clk);
        host_write(1'b1, 16'h1234);
        wait_idle(p);
        host_read(1'b1, v);
        chk(v == 16'hC001, "R10 data word kept", v, 16'hC001);
        cmp_line("R10 frame data kept", exp_frame(5'h0F, 5'h10, 1'b1, 16'hC001), 64, 1'b1);
    endtask

    task automatic t_divider;
        int div_exp [8] = '{42, 62, 16, 26, 102, 124, 124, 124};
        int p;
        for (int c = 0; c < 8; c++) begin
            rc = 0;
            host_write(1'b0, cword(5'h01, 5'h02, 3'(c), 1'b1, 1'b1));
            wait_idle(p);
            chk(rise_t[1] - rise_t[0] == div_exp[c], $sformatf("R6 period code %0d", c),
                64'(rise_t[1] - rise_t[0]), 64'(div_exp[c]));
            chk(rise_t[63] - rise_t[0] == 63 * div_exp[c], $sformatf("R6 span code %0d", c),
                64'(rise_t[63] - rise_t[0]), 64'(63 * div_exp[c]));
        end
    endtask

    task automatic t_idle_low;
        int hi = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mdc) hi++;
        end
        chk(hi == 0, "R7 MDC low while idle", hi, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fields_no_start();
        t_write(5'h11, 5'h0A, 16'hA55A);
        t_write(5'h00, 5'h1F, 16'h0001);
        t_read(5'h1F, 5'h00, 16'hC3E1);
        t_read(5'h05, 5'h15, 16'h8001);
        t_ignore_cmd();
        t_ignore_data();
        t_divider();
        t_idle_low();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

endmodule